// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This unit sits between a direct-mapped cache and the next level of memory. The cache hands it every miss as a block address. The unit first checks the oldest entry of a small queue of prefetched blocks. If that entry carries the same address, its block goes back to the cache and the memory level is not asked for it. If it does not match, the queue is discarded and the missing block is fetched on demand. After each demand fetch the unit streams ahead. It requests the following block addresses one at a time and parks each returned block at the back of the queue. It keeps doing this as long as a slot is free.

The memory side is a valid/ready request that carries a block address, plus a one-cycle response that carries a whole block. Only one request is in flight at any time. The cache side is a held request: `miss_valid` and `miss_addr` stay up until the unit returns a one-cycle `fill_valid` with the block and a flag that says whether the queue supplied it. The requester drops `miss_valid` after that pulse.

The controller has seven states:
- `ST_IDLE` takes misses and starts prefetches.
- `ST_PF_REQ` presents a prefetch request and moves to `ST_PF_RSP` on acceptance.
- `ST_PF_RSP` waits for the prefetch data. It can still serve a miss from a filled head entry. It moves to `ST_HEAD_WAIT` when the miss matches a head whose data is still on its way. It moves to `ST_DRAIN` when the miss matches nothing.
- `ST_HEAD_WAIT` returns the pending block as soon as it lands.
- `ST_DRAIN` discards the stale response, flushes the queue and moves to `ST_DM_REQ`.
- `ST_DM_REQ` presents the demand request and moves to `ST_DM_RSP` on acceptance.
- `ST_DM_RSP` delivers the demand block, restarts the address generator and returns to `ST_IDLE`.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset `fill_valid` and `mem_req_valid` are low, and no memory request is issued until the first miss has been presented.
- R2: A miss that does not match the queue head produces exactly one memory request for the missing address. The returned block is delivered with `fill_hit` low.
- R3: After a demand fetch of address A, prefetch requests go out for A+1, A+2, … in order. The addresses wrap modulo 2^ADDR_W, so the request after 0xFFFF is 0x0000.
- R4: A prefetch is requested only while the queue has a free slot, so at most DEPTH (default 4) blocks are held or pending. Removing the head frees a slot, and the next sequential prefetch follows.
- R5: A miss whose address equals the head tag, with that head's data already returned, is served from the queue. `fill_hit` is high, no memory request is made for it, and `fill_valid` rises one clock after the miss is sampled in `ST_IDLE` or `ST_PF_RSP`.
- R6: A miss that matches a head whose prefetch is still outstanding stalls until that response arrives. The block is then delivered with `fill_hit` high, and no second request is made for the address.
- R7: A miss whose address sits in the queue but not at the head counts as a queue miss. The queue is flushed, the block is fetched on demand, and prefetching restarts at the miss address plus one.
- R8: A queue miss that arrives while a prefetch is in flight waits for that response and discards it. Only then is the demand request issued. No more than one memory request is ever outstanding.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` does not change.
- R10: Each miss yields exactly one `fill_valid` pulse, one cycle wide. The pulse comes only while a miss was presented, and the delivered data equals the block stored at the miss address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss presented; held until `fill_valid` |
| miss_addr | input | ADDR_W | Block address of the miss |
| fill_valid | output | 1 | One-cycle pulse: block for the cache is ready |
| fill_data | output | BLK_W | Block returned to the cache |
| fill_hit | output | 1 | 1 = block came from the queue, 0 = demand fetch |
| mem_req_valid | output | 1 | Request to the next level is valid |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_rsp_valid | input | 1 | Response data valid (one cycle) |
| mem_rsp_data | input | BLK_W | Returned block |

## Verification
Two corners need a miss that arrives while a prefetch is still in flight: the pending-head stall and the drain of an unmatched in-flight prefetch. Both are hard to reach from the ports. The bench's memory model therefore stretches the response latency to 25 cycles. After a demand miss, the bench polls its own request log until the first prefetch has been accepted. It then presents either the address being prefetched or an unrelated one. It checks the delivered block, the hit flag and that no extra or early request was logged.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PF_REQ,
        ST_PF_RSP,
        ST_HEAD_WAIT,
        ST_DRAIN,
        ST_DM_REQ,
        ST_DM_RSP
    } sb_state_t;

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_tag,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [BLK_W-1:0]  fill_data,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [ADDR_W-1:0] head_tag,
    output logic              head_vld,
    output logic [BLK_W-1:0]  head_data,
    output logic [IDX_W-1:0]  tail_idx,
    output logic [CNT_W-1:0]  count
);

    logic [IDX_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] tag_q  [DEPTH];
    logic [BLK_W-1:0]  data_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (alloc) tail_q <= bump(tail_q);
            if (pop)   head_q <= bump(head_q);
            unique case ({alloc, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic sel_alloc, sel_fill;
        assign sel_alloc = alloc && (tail_q == IDX_W'(i));
        assign sel_fill  = fill_we && (fill_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_q[i] <= 1'b0;
            end else if (sel_alloc) begin
                vld_q[i] <= 1'b0;
            end else if (sel_fill) begin
                vld_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_alloc) tag_q[i]  <= alloc_tag;
            if (sel_fill)  data_q[i] <= fill_data;
        end
    end

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign head_tag  = tag_q[head_q];
    assign head_vld  = vld_q[head_q];
    assign head_data = data_q[head_q];
    assign tail_idx  = tail_q;
    assign count     = cnt_q;

endmodule

// File: rtl/sbuf_addr_gen.sv
module sbuf_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              armed
);

    logic [ADDR_W-1:0] next_q;
    logic              armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q  <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            next_q  <= load_addr + 1'b1;
            armed_q <= 1'b1;
        end else if (step) begin
            next_q  <= next_q + 1'b1;
        end
    end

    assign pf_addr = next_q;
    assign armed   = armed_q;

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
    import sbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 64,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    input  logic [ADDR_W-1:0] head_tag,
    input  logic              head_vld,
    input  logic [BLK_W-1:0]  head_data,
    input  logic [IDX_W-1:0]  tail_idx,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_armed,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [BLK_W-1:0]  mem_rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              fifo_flush,
    output logic              fifo_alloc,
    output logic              fifo_fill_we,
    output logic [IDX_W-1:0]  fifo_fill_idx,
    output logic              fifo_pop,
    output logic              ag_load,
    output logic              ag_step,
    output logic              fill_valid,
    output logic [BLK_W-1:0]  fill_data,
    output logic              fill_hit
);

    sb_state_t        state_q, state_d;
    logic [IDX_W-1:0] pend_idx_q;
    logic             head_match;
    logic             deliver_fifo, deliver_rsp, deliver_hit;

    assign head_match = !fifo_empty && (head_tag == miss_addr);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and actions
    always_comb begin
        state_d       = state_q;
        mem_req_valid = 1'b0;
        mem_req_addr  = pf_addr;
        fifo_flush    = 1'b0;
        fifo_alloc    = 1'b0;
        fifo_fill_we  = 1'b0;
        fifo_pop      = 1'b0;
        ag_load       = 1'b0;
        ag_step       = 1'b0;
        deliver_fifo  = 1'b0;
        deliver_rsp   = 1'b0;
        deliver_hit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_valid) begin
                    if (head_match && head_vld) begin
                        deliver_fifo = 1'b1;
                        deliver_hit  = 1'b1;
                        fifo_pop     = 1'b1;
                    end else begin
                        fifo_flush = 1'b1;
                        state_d    = ST_DM_REQ;
                    end
                end else if (pf_armed && !fifo_full) begin
                    state_d = ST_PF_REQ;
                end
            end
            ST_PF_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = pf_addr;
                if (mem_req_ready) begin
                    fifo_alloc = 1'b1;
                    ag_step    = 1'b1;
                    state_d    = ST_PF_RSP;
                end
            end
            ST_PF_RSP: begin
                fifo_fill_we = mem_rsp_valid;
                if (miss_valid && head_match && head_vld) begin
                    deliver_fifo = 1'b1;
                    deliver_hit  = 1'b1;
                    fifo_pop     = 1'b1;
                    if (mem_rsp_valid) state_d = ST_IDLE;
                end else if (miss_valid && head_match) begin
                    if (mem_rsp_valid) begin
                        fifo_fill_we = 1'b0;
                        deliver_rsp  = 1'b1;
                        deliver_hit  = 1'b1;
                        fifo_pop     = 1'b1;
                        state_d      = ST_IDLE;
                    end else begin
                        state_d = ST_HEAD_WAIT;
                    end
                end else if (miss_valid) begin
                    fifo_fill_we = 1'b0;
                    if (mem_rsp_valid) begin
                        fifo_flush = 1'b1;
                        state_d    = ST_DM_REQ;
                    end else begin
                        state_d = ST_DRAIN;
                    end
                end else if (mem_rsp_valid) begin
                    state_d = ST_IDLE;
                end
            end
            ST_HEAD_WAIT: begin
                if (mem_rsp_valid) begin
                    deliver_rsp = 1'b1;
                    deliver_hit = 1'b1;
                    fifo_pop    = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (mem_rsp_valid) begin
                    fifo_flush = 1'b1;
                    state_d    = ST_DM_REQ;
                end
            end
            ST_DM_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = miss_addr;
                if (mem_req_ready) state_d = ST_DM_RSP;
            end
            ST_DM_RSP: begin
                if (mem_rsp_valid) begin
                    deliver_rsp = 1'b1;
                    ag_load     = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign fifo_fill_idx = pend_idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          pend_idx_q <= '0;
        else if (fifo_alloc) pend_idx_q <= tail_idx;
    end

    // Registered cache-side outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid <= 1'b0;
            fill_hit   <= 1'b0;
            fill_data  <= '0;
        end else begin
            fill_valid <= deliver_fifo || deliver_rsp;
            fill_hit   <= deliver_hit;
            if (deliver_fifo)     fill_data <= head_data;
            else if (deliver_rsp) fill_data <= mem_rsp_data;
        end
    end

endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf #(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 64,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              fill_valid,
    output logic [BLK_W-1:0]  fill_data,
    output logic              fill_hit,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [BLK_W-1:0]  mem_rsp_data
);

    logic              fifo_flush, fifo_alloc, fifo_fill_we, fifo_pop;
    logic [IDX_W-1:0]  fifo_fill_idx, tail_idx;
    logic              fifo_empty, fifo_full, head_vld;
    logic [ADDR_W-1:0] head_tag, pf_addr;
    logic [BLK_W-1:0]  head_data;
    logic [CNT_W-1:0]  fifo_count;
    logic              ag_load, ag_step, pf_armed;

    sbuf_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .alloc     (fifo_alloc),
        .alloc_tag (pf_addr),
        .fill_we   (fifo_fill_we),
        .fill_idx  (fifo_fill_idx),
        .fill_data (mem_rsp_data),
        .pop       (fifo_pop),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .head_tag  (head_tag),
        .head_vld  (head_vld),
        .head_data (head_data),
        .tail_idx  (tail_idx),
        .count     (fifo_count)
    );

    sbuf_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .load_addr (miss_addr),
        .step      (ag_step),
        .pf_addr   (pf_addr),
        .armed     (pf_armed)
    );

    sbuf_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_addr     (miss_addr),
        .fifo_empty    (fifo_empty),
        .fifo_full     (fifo_full),
        .head_tag      (head_tag),
        .head_vld      (head_vld),
        .head_data     (head_data),
        .tail_idx      (tail_idx),
        .pf_addr       (pf_addr),
        .pf_armed      (pf_armed),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .fifo_flush    (fifo_flush),
        .fifo_alloc    (fifo_alloc),
        .fifo_fill_we  (fifo_fill_we),
        .fifo_fill_idx (fifo_fill_idx),
        .fifo_pop      (fifo_pop),
        .ag_load       (ag_load),
        .ag_step       (ag_step),
        .fill_valid    (fill_valid),
        .fill_data     (fill_data),
        .fill_hit      (fill_hit)
    );

endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              fill_valid,
    input logic              fill_hit,
    input logic [CNT_W-1:0]  fifo_count
);

    logic outstanding_q;
    logic seen_miss_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
            seen_miss_q   <= 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready) outstanding_q <= 1'b1;
            else if (mem_rsp_valid)             outstanding_q <= 1'b0;
            if (miss_valid) seen_miss_q <= 1'b1;
        end
    end

    // R1
    quiet_until_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_miss_q |-> !mem_req_valid);

    // R2
    demand_from_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_hit) |-> $past(mem_rsp_valid));

    // R4
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outstanding_q);

    // R8
    rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> outstanding_q);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R10
    fill_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(miss_valid));

endmodule

bind stream_prefetch_buf sbuf_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .fill_valid    (fill_valid),
    .fill_hit      (fill_hit),
    .fifo_count    (fifo_count)
);

// File: tb/tb_stream_prefetch_buf.sv
`timescale 1ns/1ps
module tb_stream_prefetch_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [15:0] miss_addr = '0;
    logic        fill_valid, fill_hit;
    logic [63:0] fill_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int          lat = 3;
    int          stall_left = 0;
    int          req_cnt = 0;
    logic [15:0] req_log [0:255];

    always #5 clk = ~clk;

    stream_prefetch_buf dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .fill_valid(fill_valid), .fill_data(fill_data), .fill_hit(fill_hit),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [63:0] blk(input logic [15:0] a);
        return {a, ~a, a ^ 16'h5A5A, 16'hC3C3};
    endfunction

    // Next-level memory model
    initial begin
        bit          busy = 1'b0;
        int          cnt = 0;
        logic [15:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (busy) begin
                cnt--;
                if (cnt <= 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = blk(a);
                    busy = 1'b0;
                end
            end
            if (!busy && mem_req_valid && rst_n) begin
                if (stall_left > 0) begin
                    mem_req_ready = 1'b0;
                    stall_left--;
                end else begin
                    mem_req_ready = 1'b1;
                    a = mem_req_addr;
                    req_log[req_cnt[7:0]] = a;
                    req_cnt++;
                    busy = 1'b1;
                    cnt = lat;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_miss(input logic [15:0] a, input string req,
                           output logic [63:0] d, output logic h, output int w);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        w = 0;
        do begin
            @(negedge clk); #1;
            w++;
        end while (!fill_valid && w < 400);
        check(fill_valid, req, "fill arrives", {63'd0, fill_valid}, 64'd1);
        d = fill_data;
        h = fill_hit;
        miss_valid = 1'b0;
        @(negedge clk); #1;
        // R10 single pulse
        check(!fill_valid, "R10", "fill pulse width", {63'd0, fill_valid}, 64'd0);
    endtask

    task automatic wait_reqs(input int n);
        int g = 0;
        while (req_cnt < n && g < 500) begin
            @(negedge clk); #1;
            g++;
        end
    endtask

    task automatic t_reset();
        idle(10);
        check(!fill_valid, "R1", "fill after reset", {63'd0, fill_valid}, 64'd0);
        check(!mem_req_valid, "R1", "req after reset", {63'd0, mem_req_valid}, 64'd0);
        check(req_cnt == 0, "R1", "no request before miss", 64'(req_cnt), 64'd0);
    endtask

    task automatic t_cold_and_fill(input logic [15:0] a);
        logic [63:0] d; logic h; int w; int b;
        b = req_cnt;
        do_miss(a, "R2", d, h, w);
        check(d == blk(a), "R2", "demand data", d, blk(a));
        check(!h, "R2", "demand hit flag", {63'd0, h}, 64'd0);
        check(req_log[b[7:0]] == a, "R2", "demand address", 64'(req_log[b[7:0]]), 64'(a));
        idle(60);
        check(req_cnt == b + 5, "R4", "stops when full", 64'(req_cnt), 64'(b + 5));
        for (int k = 1; k <= 4; k++) begin
            logic [15:0] e;
            e = a + 16'(k);
            check(req_log[8'(b + k)] == e, "R3", "sequential prefetch", 64'(req_log[8'(b + k)]), 64'(e));
        end
    endtask

    task automatic t_head_hit(input logic [15:0] a);
        logic [63:0] d; logic h; int w; int b;
        b = req_cnt;
        do_miss(a, "R5", d, h, w);
        check(d == blk(a), "R5", "head data", d, blk(a));
        check(h, "R5", "head hit flag", {63'd0, h}, 64'd1);
        check(w == 1, "R5", "hit latency", 64'(w), 64'd1);
        idle(30);
        check(req_cnt == b + 1, "R4", "freed slot refilled", 64'(req_cnt), 64'(b + 1));
        check(req_log[b[7:0]] == a + 16'd4, "R3", "next prefetch", 64'(req_log[b[7:0]]), 64'(a + 16'd4));
    endtask

    task automatic t_deep_miss(input logic [15:0] a);
        logic [63:0] d; logic h; int w; int b;
        b = req_cnt;
        do_miss(a, "R7", d, h, w);
        check(d == blk(a), "R7", "deep entry data", d, blk(a));
        check(!h, "R7", "deep entry is a miss", {63'd0, h}, 64'd0);
        idle(60);
        check(req_log[b[7:0]] == a, "R7", "demand re-fetch", 64'(req_log[b[7:0]]), 64'(a));
        check(req_log[8'(b + 1)] == a + 16'd1, "R7", "restart at miss+1",
              64'(req_log[8'(b + 1)]), 64'(a + 16'd1));
        check(req_cnt == b + 5, "R7", "refilled after flush", 64'(req_cnt), 64'(b + 5));
    endtask

    task automatic t_wrap();
        logic [63:0] d; logic h; int w; int b;
        b = req_cnt;
        do_miss(16'hFFFE, "R3", d, h, w);
        idle(60);
        check(req_log[8'(b + 1)] == 16'hFFFF, "R3", "wrap step 1", 64'(req_log[8'(b + 1)]), 64'hFFFF);
        check(req_log[8'(b + 2)] == 16'h0000, "R3", "wrap to zero", 64'(req_log[8'(b + 2)]), 64'h0);
    endtask

    task automatic t_pending_head(input logic [15:0] a);
        logic [63:0] d; logic h; int w; int b;
        lat = 25;
        b = req_cnt;
        do_miss(a, "R2", d, h, w);
        wait_reqs(b + 2);
        do_miss(a + 16'd1, "R6", d, h, w);
        check(d == blk(a + 16'd1), "R6", "pending head data", d, blk(a + 16'd1));
        check(h, "R6", "pending head hit flag", {63'd0, h}, 64'd1);
        check(w > 5, "R6", "stalled for response", 64'(w), 64'd6);
        check(req_log[8'(b + 1)] == a + 16'd1, "R6", "no duplicate request",
              64'(req_log[8'(b + 1)]), 64'(a + 16'd1));
        idle(200);
    endtask

    task automatic t_drain(input logic [15:0] c, input logic [15:0] x);
        logic [63:0] d; logic h; int w; int b;
        lat = 25;
        b = req_cnt;
        do_miss(c, "R2", d, h, w);
        wait_reqs(b + 2);
        do_miss(x, "R8", d, h, w);
        check(d == blk(x), "R8", "stale response discarded", d, blk(x));
        check(!h, "R8", "drain miss flag", {63'd0, h}, 64'd0);
        check(req_log[8'(b + 2)] == x, "R8", "demand after drain",
              64'(req_log[8'(b + 2)]), 64'(x));
        idle(200);
    endtask

    task automatic t_ready_stall(input logic [15:0] e);
        logic [63:0] d; logic h; int w; int b;
        lat = 2;
        b = req_cnt;
        stall_left = 6;
        do_miss(e, "R9", d, h, w);
        check(d == blk(e), "R9", "data after ready stall", d, blk(e));
        check(req_log[b[7:0]] == e, "R9", "held address accepted", 64'(req_log[b[7:0]]), 64'(e));
        check(w >= 8, "R9", "stall lengthened fetch", 64'(w), 64'd8);
        idle(40);
    endtask

    task automatic t_hit_in_flight(input logic [15:0] e);
        logic [63:0] d; logic h; int w;
        lat = 15;
        do_miss(e + 16'd1, "R5", d, h, w);
        check(h && d == blk(e + 16'd1), "R5", "first hit", d, blk(e + 16'd1));
        idle(2);
        do_miss(e + 16'd2, "R5", d, h, w);
        check(d == blk(e + 16'd2), "R5", "hit during prefetch data", d, blk(e + 16'd2));
        check(h, "R5", "hit during prefetch flag", {63'd0, h}, 64'd1);
        check(w <= 3, "R5", "not held by prefetch", 64'(w), 64'd3);
        idle(40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_and_fill(16'h0100);
        t_head_hit(16'h0101);
        t_deep_miss(16'h0104);
        t_wrap();
        t_pending_head(16'h2000);
        t_drain(16'h3000, 16'h4000);
        t_ready_stall(16'h5000);
        t_hit_in_flight(16'h5000);
        finish_run();
    end

endmodule